// File: doc/BRIEF.md
# Rotating-Priority Request Arbiter

This block chooses one winner per clock cycle among eight request lines, and shares grants fairly over time by rotating priority. A pointer register holds the index of the requester that now has the lowest priority. The winner each cycle is the first active request found by scanning upward from the slot just after that pointer, wrapping past the top index back to zero. Once a grant is issued, the pointer takes the winner's index, so the requester just served drops to the bottom of the order.

The grant is combinational from the present request vector and pointer, and the pointer moves on the next rising clock edge. The winner is given in two forms: a binary index and a one-hot vector made by a binary-to-one-hot decoder. A population count of the active request lines is also provided. This count lets a display or a load monitor show how many requesters are waiting.

The pointer update is driven by a two-state action enumeration. `PTR_HOLD` is selected when no request is active, and the pointer keeps its value. `PTR_ADVANCE` is selected when a winner exists, and the pointer loads the winner index. Those are the only two transitions. The asynchronous active-low reset forces the pointer to its top index.

Top module: `rotating_grant_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, the lowest-priority pointer `prio_idx` reads NUM_REQ-1 (7), so request 0 is first in line.
- R2: `gnt_vld` is high exactly when at least one bit of `req` is high. `gnt_idx` is the first active index met when scanning `prio_idx+1`, `prio_idx+2`, … modulo 8.
- R3: On each rising edge where `gnt_vld` is high, `prio_idx` loads the value `gnt_idx` had before that edge.
- R4: With `req` all zeros, `gnt_vld` is 0, `gnt_onehot` is all zeros, and `prio_idx` keeps its value across the edge.
- R5: When `gnt_vld` is high, `gnt_onehot` has exactly one bit set, at bit position `gnt_idx` (bit 0 = request 0).
- R6: `req_count` equals the number of set bits in `req`, from 0 to 8, as an unsigned binary value.
- R7: With every request held high from reset, successive grants run 0,1,2,…,7 and then return to 0.
- R8: A grant never names an inactive request: `gnt_vld` high implies `req[gnt_idx]` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 8 | Request lines, bit i = requester i |
| gnt_vld | output | 1 | A grant is issued this cycle |
| gnt_idx | output | 3 | Binary index of the winner |
| gnt_onehot | output | 8 | One-hot form of the winner, all zeros when idle |
| req_count | output | 4 | Number of active request lines |
| prio_idx | output | 3 | Index of the current lowest-priority requester |

## Verification
The bench builds the arbiter with its default of eight requesters. It therefore exercises the three-bit pointer wrapping from 7 back to 0 and the four-bit count reaching its full value of 8. With eight lines, every one of the 256 request patterns can be walked exhaustively while the pointer keeps rotating, so each pattern meets many pointer positions. Directed phases add the all-high fairness run, a lone request that sits exactly at the pointer (the longest scan), and idle cycles between grants.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;

    // Default number of requesters for this arbiter family.
    localparam int ARB_DEF_REQS = 8;

    // What the pointer register does on the coming edge.
    typedef enum logic [0:0] {
        PTR_HOLD    = 1'b0,
        PTR_ADVANCE = 1'b1
    } ptr_action_e;

endpackage

// File: rtl/rr_scan.sv
`timescale 1ns/1ps
// Rotating search: first active request after the lowest-priority slot.
module rr_scan #(
    parameter int NREQ = 8,
    parameter int IW   = 3
) (
    input  logic [NREQ-1:0] req,
    input  logic [IW-1:0]   last_idx,
    output logic            found,
    output logic [IW-1:0]   win_idx
);
    localparam int SW = IW + 2;

    logic [SW-1:0] slot;

    always_comb begin
        found   = 1'b0;
        win_idx = last_idx;
        slot    = '0;
        // walk from the farthest slot to the nearest so the nearest wins
        for (int k = NREQ; k >= 1; k--) begin
            slot = {2'b00, last_idx} + SW'(k);
            if (slot >= SW'(NREQ)) begin
                slot = slot - SW'(NREQ);
            end
            if (req[slot[IW-1:0]]) begin
                found   = 1'b1;
                win_idx = slot[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/idx_to_onehot.sv
`timescale 1ns/1ps
// Binary index to one-hot, gated by an enable.
module idx_to_onehot #(
    parameter int NOUT = 8,
    parameter int IW   = 3
) (
    input  logic            en,
    input  logic [IW-1:0]   idx,
    output logic [NOUT-1:0] onehot
);
    for (genvar g = 0; g < NOUT; g++) begin : g_dec
        assign onehot[g] = en && (idx == IW'(g));
    end
endmodule

// File: rtl/req_popcount.sv
`timescale 1ns/1ps
// Number of set bits in the request vector.
module req_popcount #(
    parameter int NIN = 8,
    parameter int CW  = 4
) (
    input  logic [NIN-1:0] bits_in,
    output logic [CW-1:0]  total
);
    always_comb begin
        total = '0;
        for (int i = 0; i < NIN; i++) begin
            total = total + CW'(bits_in[i]);
        end
    end
endmodule

// File: rtl/rotating_grant_arbiter.sv
`timescale 1ns/1ps
module rotating_grant_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_REQ = ARB_DEF_REQS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_REQ-1:0]          req,
    output logic                        gnt_vld,
    output logic [$clog2(NUM_REQ)-1:0]  gnt_idx,
    output logic [NUM_REQ-1:0]          gnt_onehot,
    output logic [$clog2(NUM_REQ+1)-1:0] req_count,
    output logic [$clog2(NUM_REQ)-1:0]  prio_idx
);
    localparam int IW = $clog2(NUM_REQ);
    localparam int CW = $clog2(NUM_REQ + 1);
    localparam logic [IW-1:0] PTR_RESET = IW'(NUM_REQ - 1);

    logic [IW-1:0] ptr_q;
    logic          scan_found;
    logic [IW-1:0] scan_win;
    ptr_action_e   action;

    rr_scan #(.NREQ(NUM_REQ), .IW(IW)) u_scan (
        .req      (req),
        .last_idx (ptr_q),
        .found    (scan_found),
        .win_idx  (scan_win)
    );

    idx_to_onehot #(.NOUT(NUM_REQ), .IW(IW)) u_dec (
        .en     (scan_found),
        .idx    (scan_win),
        .onehot (gnt_onehot)
    );

    req_popcount #(.NIN(NUM_REQ), .CW(CW)) u_cnt (
        .bits_in (req),
        .total   (req_count)
    );

    always_comb begin
        action = scan_found ? PTR_ADVANCE : PTR_HOLD;
    end

    // pointer register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= PTR_RESET;
        end else begin
            unique case (action)
                PTR_ADVANCE: ptr_q <= scan_win;
                PTR_HOLD:    ptr_q <= ptr_q;
                default:     ptr_q <= ptr_q;
            endcase
        end
    end

    // outputs
    always_comb begin
        gnt_vld  = scan_found;
        gnt_idx  = scan_win;
        prio_idx = ptr_q;
    end
endmodule

// File: rtl/rotating_grant_arbiter_chk.sv
`timescale 1ns/1ps
module rotating_grant_arbiter_chk #(
    parameter int NUM_REQ = 8,
    parameter int IW      = 3,
    parameter int CW      = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] req,
    input logic               gnt_vld,
    input logic [IW-1:0]      gnt_idx,
    input logic [NUM_REQ-1:0] gnt_onehot,
    input logic [CW-1:0]      req_count,
    input logic [IW-1:0]      prio_idx
);
    logic run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    AST_VLD_MATCHES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld == (req != '0)); // R2
    AST_PTR_LOADS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(gnt_vld)) |-> (prio_idx == $past(gnt_idx))); // R3
    AST_PTR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !$past(gnt_vld)) |-> $stable(prio_idx)); // R4
    AST_IDLE_NO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_vld |-> (gnt_onehot == '0)); // R4
    AST_ONEHOT_AT_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> ($countones(gnt_onehot) == 1 && gnt_onehot[gnt_idx])); // R5
    AST_COUNT_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        int'(req_count) == $countones(req)); // R6
    AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> req[gnt_idx]); // R8
endmodule

bind rotating_grant_arbiter rotating_grant_arbiter_chk #(
    .NUM_REQ (NUM_REQ),
    .IW      ($clog2(NUM_REQ)),
    .CW      ($clog2(NUM_REQ+1))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .gnt_vld    (gnt_vld),
    .gnt_idx    (gnt_idx),
    .gnt_onehot (gnt_onehot),
    .req_count  (req_count),
    .prio_idx   (prio_idx)
);

// File: tb/rotating_grant_arbiter_test.sv
`timescale 1ns/1ps
module rotating_grant_arbiter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0;
    logic       gnt_vld;
    logic [2:0] gnt_idx;
    logic [7:0] gnt_onehot;
    logic [3:0] req_count;
    logic [2:0] prio_idx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rotating_grant_arbiter uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .gnt_vld    (gnt_vld),
        .gnt_idx    (gnt_idx),
        .gnt_onehot (gnt_onehot),
        .req_count  (req_count),
        .prio_idx   (prio_idx)
    );

    typedef struct {
        logic       vld;
        logic [2:0] idx;
        logic [7:0] oh;
        logic [3:0] cnt;
        logic [2:0] prio;
        string      gtag;
        string      ptag;
    } exp_t;

    exp_t       sb_q[$];
    logic [2:0] model_ptr;

    task automatic check(string rq, string what, int act, int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    // driver: apply one request pattern and push what must come out
    task automatic drive(logic [7:0] r, string gtag);
        exp_t e;
        int   ones;
        @(posedge clk);
        #1;
        req    = r;
        ones   = 0;
        e.vld  = 1'b0;
        e.idx  = model_ptr;
        for (int i = 0; i < 8; i++) ones += int'(r[i]);
        for (int k = 8; k >= 1; k--) begin
            int p;
            p = (int'(model_ptr) + k) % 8;
            if (r[p]) begin
                e.vld = 1'b1;
                e.idx = 3'(p);
            end
        end
        e.oh   = e.vld ? (8'd1 << e.idx) : 8'd0;
        e.cnt  = 4'(ones);
        e.prio = model_ptr;
        e.gtag = (r == 8'd0) ? "R4" : gtag;
        e.ptag = (r == 8'd0) ? "R4" : "R3";
        sb_q.push_back(e);
        if (e.vld) model_ptr = e.idx;
    endtask

    // monitor: compare at the falling edge
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.gtag, "gnt_vld", int'(gnt_vld), int'(e.vld));
            if (e.vld) check(e.gtag, "gnt_idx", int'(gnt_idx), int'(e.idx));
            check(e.vld ? "R5" : "R4", "gnt_onehot", int'(gnt_onehot), int'(e.oh));
            check("R6", "req_count", int'(req_count), int'(e.cnt));
            check(e.ptag, "prio_idx", int'(prio_idx), int'(e.prio));
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model_ptr = 3'd7;
        repeat (2) @(negedge clk);
        // R1: pointer during reset
        check("R1", "prio_idx in reset", int'(prio_idx), 7);
        check("R1", "gnt_vld in reset", int'(gnt_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "prio_idx after reset", int'(prio_idx), 7);

        // R7: all high from reset rotates 0..7 then 0
        for (int c = 0; c < 10; c++) drive(8'hFF, "R7");

        // R4: idle cycles keep pointer, then one lone request
        drive(8'h00, "R4");
        drive(8'h00, "R4");
        drive(8'h08, "R2");
        // lone request at the pointer itself: full wrap
        drive(8'h08, "R2");
        drive(8'h80, "R2");
        drive(8'h01, "R2");
        drive(8'h81, "R2");
        drive(8'h81, "R2");

        // R2/R6: every pattern, pointer keeps moving
        for (int v = 0; v < 256; v++) drive(8'(v), "R2");
        for (int v = 255; v >= 0; v--) drive(8'(v), "R2");

        // random mix with idle gaps
        for (int t = 0; t < 400; t++) begin
            logic [7:0] r;
            r = 8'($urandom);
            if (t % 7 == 0) r = 8'h00;
            drive(r, "R2");
        end

        @(posedge clk);
        #1 req = '0;
        repeat (2) @(negedge clk);
        check("R8", "scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule